// File: doc/BRIEF.md
# Pipeline Bypass and Interlock Control

This block makes the forwarding, interlock and squash decisions for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). While an instruction is in decode, the block compares its two source register numbers with the destinations of the instructions now in execute and memory. From this it chooses where each ALU operand will come from once the instruction reaches execute. The chosen selects are registered, so they move into execute together with the instruction.

A load in execute that feeds the decoding instruction raises a one-cycle interlock. The PC and the decode register hold, and execute receives a bubble. A branch resolved in decode either squashes the single instruction fetched behind it or lets that instruction run as a delay slot, depending on a mode input. The register file is assumed to write in the first half of a cycle and read in the second half. For that reason a producer already in writeback needs no bypass.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: After reset, both registered operand selects are 0, which selects the register-file value.
- R2: When the execute-stage instruction writes a nonzero register equal to a decode source, and there is no stall, that operand's select becomes 1 at the next clock edge. Select 1 means the latch after execute.
- R3: When only the memory-stage instruction writes a nonzero register equal to a decode source, that operand's select becomes 2 at the next clock edge. Select 2 means the latch after memory.
- R4: When the execute-stage and memory-stage instructions both write the same source register, the execute-stage match wins and the select is 1.
- R5: A source that matches no writing producer in execute or memory, including a producer whose write enable is low, gets select 0. Select 3 is never produced.
- R6: Register 0 is never forwarded and never causes a stall, even when a load in execute targets it.
- R7: A load in execute whose nonzero destination matches either decode source raises the hold and bubble outputs in that same cycle. Both selects are 0 after the next edge, because execute has received a no-op.
- R8: After a load-use hold, the consumer, with the load now in memory, gets select 2 for the dependent operand.
- R9: A taken branch in decode raises the flush output in the same cycle when the delay-slot mode input is 0. It does not raise flush when the mode input is 1.
- R10: Flush is never raised while hold is raised. With no load hazard, hold and bubble stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idSrcA | input | REG_W | Decode instruction source register for operand A |
| idSrcB | input | REG_W | Decode instruction source register for operand B |
| brTaken | input | 1 | Branch in decode resolved taken this cycle |
| delaySlotMode | input | 1 | 1 lets the instruction behind a branch complete, 0 squashes it |
| exDst | input | REG_W | Destination register of the execute-stage instruction |
| exWrEn | input | 1 | Execute-stage instruction writes a register |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| memDst | input | REG_W | Destination register of the memory-stage instruction |
| memWrEn | input | 1 | Memory-stage instruction writes a register |
| stallHold | output | 1 | Hold the PC and the decode register |
| bubbleEx | output | 1 | Load a no-op into the execute register |
| flushFetch | output | 1 | Replace the instruction fetched behind the branch with a bubble |
| exSelA | output | 2 | Registered operand A select (0 register file, 1 post-execute, 2 post-memory) |
| exSelB | output | 2 | Registered operand B select, same encoding |

## Verification
The bench builds the block with its default of 32 registers, which gives 5-bit register numbers. This puts both register 0 and the highest register, 31, within reach of the forwarding and interlock comparisons. The scenarios cover back-to-back ALU dependencies, a producer two slots ahead, a double match, a load-use pair followed by its post-memory bypass, and taken branches in both slot modes. The registered selects are observed one edge after the decision, and hold and flush are observed in the cycle of the decision.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF     = 2'd0,
    SEL_EXLAT  = 2'd1,
    SEL_MEMLAT = 2'd2
  } fwdSel_e;

  typedef struct packed {
    logic hold;
    logic bubble;
    logic squash;
  } strobes_t;

  localparam int NUM_OPS = 2;
endpackage

// File: rtl/hz_ctl.sv
module hz_ctl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_OPS-1:0][REG_W-1:0] idSrc,
  input  logic                          brTaken,
  input  logic                          delaySlotMode,
  input  logic [REG_W-1:0]              exDst,
  input  logic                          exWrEn,
  input  logic                          exIsLoad,
  output strobes_t                      stb
);
  logic [NUM_OPS-1:0] srcHit;
  logic loadUse;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_hit
    assign srcHit[i] = (idSrc[i] != '0) && (idSrc[i] == exDst);
  end

  always_comb begin
    loadUse    = exIsLoad && exWrEn && (|srcHit);
    stb.hold   = loadUse;
    stb.bubble = loadUse;
    stb.squash = brTaken && !delaySlotMode && !loadUse;
  end
endmodule

// File: rtl/hz_fwd.sv
module hz_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      stb,
  input  logic [NUM_OPS-1:0][REG_W-1:0] idSrc,
  input  logic [REG_W-1:0]              exDst,
  input  logic                          exWrEn,
  input  logic [REG_W-1:0]              memDst,
  input  logic                          memWrEn,
  output fwdSel_e [NUM_OPS-1:0]         exSel
);
  fwdSel_e [NUM_OPS-1:0] nextSel;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic exMatch, memMatch;
    assign exMatch  = exWrEn && (idSrc[i] != '0) && (idSrc[i] == exDst);
    assign memMatch = memWrEn && (idSrc[i] != '0) && (idSrc[i] == memDst);

    always_comb begin
      if (exMatch)       nextSel[i] = SEL_EXLAT;
      else if (memMatch) nextSel[i] = SEL_MEMLAT;
      else               nextSel[i] = SEL_RF;
    end

    always_ff @(posedge clk) begin
      if (!rstN)           exSel[i] <= SEL_RF;
      else if (stb.bubble) exSel[i] <= SEL_RF;
      else                 exSel[i] <= nextSel[i];
    end
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] idSrcA,
  input  logic [REG_W-1:0] idSrcB,
  input  logic             brTaken,
  input  logic             delaySlotMode,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWrEn,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrEn,
  output logic             stallHold,
  output logic             bubbleEx,
  output logic             flushFetch,
  output logic [1:0]       exSelA,
  output logic [1:0]       exSelB
);
  logic [NUM_OPS-1:0][REG_W-1:0] idSrc;
  strobes_t stb;
  fwdSel_e [NUM_OPS-1:0] exSel;

  assign idSrc = {idSrcB, idSrcA};

  hz_ctl #(.REG_W(REG_W)) u_ctl (
    .idSrc(idSrc), .brTaken(brTaken), .delaySlotMode(delaySlotMode),
    .exDst(exDst), .exWrEn(exWrEn), .exIsLoad(exIsLoad), .stb(stb)
  );

  hz_fwd #(.REG_W(REG_W)) u_fwd (
    .clk(clk), .rstN(rstN), .stb(stb), .idSrc(idSrc),
    .exDst(exDst), .exWrEn(exWrEn), .memDst(memDst), .memWrEn(memWrEn),
    .exSel(exSel)
  );

  assign stallHold  = stb.hold;
  assign bubbleEx   = stb.bubble;
  assign flushFetch = stb.squash;
  assign exSelA     = exSel[0];
  assign exSelB     = exSel[1];
endmodule

// File: rtl/hz_chk.sv
module hz_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] idSrcA,
  input logic [REG_W-1:0] idSrcB,
  input logic             brTaken,
  input logic             delaySlotMode,
  input logic [REG_W-1:0] exDst,
  input logic             exWrEn,
  input logic             exIsLoad,
  input logic             stallHold,
  input logic             bubbleEx,
  input logic             flushFetch,
  input logic [1:0]       exSelA,
  input logic [1:0]       exSelB
);
  AST_BUBBLE_CLEARS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    bubbleEx |=> (exSelA == 2'd0 && exSelB == 2'd0)); // R7
  AST_EX_FWD_A: assert property (@(posedge clk) disable iff (!rstN)
    (!stallHold && exWrEn && exDst != '0 && exDst == idSrcA) |=> exSelA == 2'd1); // R2
  AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (idSrcA == '0 && idSrcB == '0) |=> (exSelA == 2'd0 && exSelB == 2'd0)); // R6
  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (idSrcA == '0 && idSrcB == '0) |-> !stallHold); // R6
  AST_NO_FLUSH_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    delaySlotMode |-> !flushFetch); // R9
  AST_FLUSH_NOT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    stallHold |-> !flushFetch); // R10
  AST_STALL_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stallHold |-> (exIsLoad && exWrEn)); // R10
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (exSelA != 2'd3 && exSelB != 2'd3)); // R5
  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && !delaySlotMode && !stallHold) |-> flushFetch); // R9
endmodule

bind pipe_hazard_ctl hz_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .idSrcA(idSrcA), .idSrcB(idSrcB),
  .brTaken(brTaken), .delaySlotMode(delaySlotMode), .exDst(exDst),
  .exWrEn(exWrEn), .exIsLoad(exIsLoad), .stallHold(stallHold),
  .bubbleEx(bubbleEx), .flushFetch(flushFetch), .exSelA(exSelA), .exSelB(exSelB)
);

// File: tb/sim_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module sim_pipe_hazard_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] idSrcA = '0, idSrcB = '0, exDst = '0, memDst = '0;
  logic brTaken = 1'b0, delaySlotMode = 1'b0, exWrEn = 1'b0, exIsLoad = 1'b0, memWrEn = 1'b0;
  logic stallHold, bubbleEx, flushFetch;
  logic [1:0] exSelA, exSelB;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pipe_hazard_ctl u0 (
    .clk(clk), .rstN(rstN), .idSrcA(idSrcA), .idSrcB(idSrcB),
    .brTaken(brTaken), .delaySlotMode(delaySlotMode), .exDst(exDst),
    .exWrEn(exWrEn), .exIsLoad(exIsLoad), .memDst(memDst), .memWrEn(memWrEn),
    .stallHold(stallHold), .bubbleEx(bubbleEx), .flushFetch(flushFetch),
    .exSelA(exSelA), .exSelB(exSelB)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // set decode sources, execute producer, memory producer, branch inputs
  task automatic drive(logic [4:0] sa, logic [4:0] sb, logic [4:0] ed, logic ew, logic el,
                       logic [4:0] md, logic mw, logic br, logic dm);
    idSrcA = sa; idSrcB = sb; exDst = ed; exWrEn = ew; exIsLoad = el;
    memDst = md; memWrEn = mw; brTaken = br; delaySlotMode = dm;
    #1;
  endtask

  task automatic nextEdge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 selA", exSelA, 0);
    check("R1 selB", exSelB, 0);
    check("R10 hold idle", stallHold, 0);
  endtask

  task automatic t_exFwd();
    drive(5'd3, 5'd9, 5'd3, 1, 0, 5'd0, 0, 0, 0);
    check("R10 no hold alu", stallHold, 0);
    nextEdge();
    check("R2 selA ex", exSelA, 1);
    check("R5 selB none", exSelB, 0);
    drive(5'd31, 5'd31, 5'd31, 1, 0, 5'd0, 0, 0, 0);
    nextEdge();
    check("R2 selA r31", exSelA, 1);
    check("R2 selB r31", exSelB, 1);
  endtask

  task automatic t_memFwd();
    drive(5'd4, 5'd6, 5'd8, 1, 0, 5'd4, 1, 0, 0);
    nextEdge();
    check("R3 selA mem", exSelA, 2);
    check("R3 selB none", exSelB, 0);
  endtask

  task automatic t_priority();
    drive(5'd5, 5'd5, 5'd5, 1, 0, 5'd5, 1, 0, 0);
    nextEdge();
    check("R4 selA", exSelA, 1);
    check("R4 selB", exSelB, 1);
  endtask

  task automatic t_noFwd();
    drive(5'd7, 5'd2, 5'd7, 0, 1, 5'd2, 0, 0, 0);
    check("R5 no hold wr off", stallHold, 0);
    nextEdge();
    check("R5 selA wr off", exSelA, 0);
    check("R5 selB wr off", exSelB, 0);
  endtask

  task automatic t_zero();
    drive(5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 0);
    check("R6 no hold r0", stallHold, 0);
    check("R6 no bubble r0", bubbleEx, 0);
    nextEdge();
    check("R6 selA r0", exSelA, 0);
    check("R6 selB r0", exSelB, 0);
  endtask

  task automatic t_loadUse();
    // prime selects to a nonzero value first
    drive(5'd7, 5'd7, 5'd7, 1, 0, 5'd0, 0, 0, 0);
    nextEdge();
    drive(5'd1, 5'd7, 5'd7, 1, 1, 5'd0, 0, 0, 0);
    check("R7 hold", stallHold, 1);
    check("R7 bubble", bubbleEx, 1);
    nextEdge();
    check("R7 selA bubble", exSelA, 0);
    check("R7 selB bubble", exSelB, 0);
    drive(5'd1, 5'd7, 5'd0, 0, 0, 5'd7, 1, 0, 0);
    check("R7 hold released", stallHold, 0);
    nextEdge();
    check("R8 selB post-mem", exSelB, 2);
    check("R8 selA none", exSelA, 0);
  endtask

  task automatic t_branch();
    drive(5'd2, 5'd3, 5'd0, 0, 0, 5'd0, 0, 1, 0);
    check("R9 squash flush", flushFetch, 1);
    nextEdge();
    drive(5'd2, 5'd3, 5'd0, 0, 0, 5'd0, 0, 1, 1);
    check("R9 slot no flush", flushFetch, 0);
    nextEdge();
    drive(5'd2, 5'd3, 5'd3, 1, 1, 5'd0, 0, 1, 0);
    check("R10 hold", stallHold, 1);
    check("R10 no flush in hold", flushFetch, 0);
    nextEdge();
    drive(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, 0);
    check("R9 no branch", flushFetch, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nextEdge();
    t_reset();
    t_exFwd();
    t_memFwd();
    t_priority();
    t_noFwd();
    t_zero();
    t_loadUse();
    t_branch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule